// File: doc/BRIEF.md
# PLL Feedback Multiplier Code Converter

This block translates a PLL feedback multiplier between its plain binary value and the scrambled 17-bit code that the PLL's feedback divider expects, in both directions. The scrambled code is the state of a 15-bit feedback shift register. That state is reached after a number of steps that depends on the multiplier. The converter walks this register one step per clock, so a conversion takes a different number of cycles for each value. When it encodes, the block also works out the two loop-bandwidth fields (proportional and integral selects) from the binary multiplier. Boot firmware or a clock-configuration sequencer uses it to build the register words before it programs a PLL. It also uses it to turn a code read back from hardware into a multiplier.

The caller sets `dir_dec` and the matching operand, then pulses `start` while `busy` is low. `busy` rises on the next clock and stays high up to and including the single cycle in which `valid` is high. The result ports then hold their values until the next conversion completes.

The control state machine has five states. IDLE waits for a request. ENCODE steps the register forward. DIVIDE runs the restoring divider for the mid-range integral select. DECODE steps the register backward. DONE presents the result.

The transitions are:
- IDLE to DONE on a special-case request.
- IDLE to ENCODE on any other encode request.
- IDLE to DECODE on any other decode request.
- ENCODE to DIVIDE when the walk ends and the multiplier lies in 60..500.
- ENCODE to DONE when the walk ends and the multiplier lies outside 60..500.
- DIVIDE to DONE when the quotient is ready.
- DECODE to DONE on a match or when the counter is exhausted.
- DONE to IDLE always.

Top module: `pll_mcode_conv`

## Requirements
- R1: During and right after reset, `busy`, `valid` and `bad_code` are 0 and all result ports are 0.
- R2: Encoding multiplier 0 yields code 0x00000, multiplier 1 yields 0x18003, and multiplier 2 yields 0x10003. None of these walks the register.
- R3: Encoding any other multiplier m starts from state 0x04000 and applies one forward step for each value from m to 32768 inclusive. A forward step maps x to ((x xor x>>1)&1)<<14 | (x>>1)&0xFFFF. A multiplier above 32768 therefore yields 0x04000. `msel_out` echoes m.
- R4: Decoding code 0x18003 yields 1 and code 0x10003 yields 2.
- R5: Decoding any other code x uses a counter that starts at 32769. While x is not 0x04000 and the counter is not 0, the block replaces x with (x xor x>>14)&1 | (x<<1)&0x7FFF and decrements the counter. The result is the final counter value, so code 0x04000 itself decodes to 32769.
- R6: A decode that exhausts the counter sets `bad_code` to 1 with `msel_out` = 0.
- R7: On encode, `selp_out` is (m>>1)+1 for m below 60 and 31 otherwise.
- R8: On encode, `seli_out` is 1 for m > 16384, 2 for m > 8192, 4 for m > 2048, 8 for m >= 501, and (m & 0x3C)+4 for m < 60.
- R9: For 60 <= m <= 500, `seli_out` is 4*q when 1024 divides exactly by m+9 and 4*(q+1) otherwise, where q = floor(1024/(m+9)). An iterative divider computes q inside the busy period.
- R10: `busy` is 1 from the clock after an accepted `start` through the one cycle in which `valid` is 1. `valid` is never high for two cycles in a row.
- R11: A `start` pulse while `busy` is 1 is ignored: it produces no extra result and does not change the running one.
- R12: Result ports change only in the cycle in which `valid` is 1 and hold otherwise. After a decode, `mdec_out`, `selp_out` and `seli_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion (accepted only while idle) |
| dir_dec | input | 1 | 0 = binary to code, 1 = code to binary |
| msel_in | input | 16 | Binary multiplier operand |
| mdec_in | input | 17 | Scrambled code operand |
| busy | output | 1 | Conversion in progress |
| valid | output | 1 | One-cycle result strobe |
| msel_out | output | 16 | Binary multiplier result (echo on encode) |
| mdec_out | output | 17 | Scrambled code result (0 after decode) |
| selp_out | output | 5 | Proportional bandwidth select |
| seli_out | output | 6 | Integral bandwidth select |
| bad_code | output | 1 | Decode found no matching multiplier |

## Verification
The hardest situations to reach are the ones that sit at the far end of the register walk. Examples are an unmatchable code such as zero, which must run all 32769 backward steps before `bad_code` rises, and mid-range multipliers, whose integral select comes from the divider only after more than thirty-two thousand forward steps. The bench drives these cases directly, accepts the long busy periods, and sizes its cycle budget around them. A restart request is pushed into the middle of a long forward walk so that a wrongly accepted request would show up as an extra or corrupted result in the scoreboard.

// File: rtl/pll_mcode_pkg.sv
package pll_mcode_pkg;

    localparam int MUL_W  = 16;
    localparam int CODE_W = 17;
    localparam int TAP_HI = 14;
    localparam int SELP_W = 5;
    localparam int SELI_W = 6;
    localparam int QUO_W  = 11;
    localparam int DVS_W  = 10;

    localparam logic [MUL_W-1:0]  MSEL_TOP  = 16'd32768;
    localparam logic [MUL_W-1:0]  DEC_START = 16'd32769;
    localparam logic [CODE_W-1:0] SEED      = 17'h04000;
    localparam logic [CODE_W-1:0] CODE_M1   = 17'h18003;
    localparam logic [CODE_W-1:0] CODE_M2   = 17'h10003;

    localparam logic [QUO_W-1:0]  BW_NUM    = 11'd1024;
    localparam logic [DVS_W-1:0]  BW_OFS    = 10'd9;
    localparam logic [MUL_W-1:0]  MID_LO    = 16'd60;
    localparam logic [MUL_W-1:0]  MID_HI    = 16'd500;
    localparam logic [MUL_W-1:0]  TH_SELI1  = 16'd16384;
    localparam logic [MUL_W-1:0]  TH_SELI2  = 16'd8192;
    localparam logic [MUL_W-1:0]  TH_SELI4  = 16'd2048;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENCODE,
        S_DIVIDE,
        S_DECODE,
        S_DONE
    } cvt_state_t;

endpackage

// File: rtl/pll_mcode_lfsr.sv
module pll_mcode_lfsr #(
    parameter int CODE_W = 17,
    parameter int TAP_HI = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_val,
    input  logic              fwd,
    input  logic              bwd,
    output logic [CODE_W-1:0] state
);
    logic [CODE_W-1:0] nxt_fwd;
    logic [CODE_W-1:0] nxt_bwd;

    // forward: shift right, feedback of bit0^bit1 into the top tap
    always_comb begin
        nxt_fwd = '0;
        nxt_fwd[CODE_W-2:0] = state[CODE_W-1:1];
        nxt_fwd[TAP_HI] = nxt_fwd[TAP_HI] | (state[0] ^ state[1]);
    end

    // backward: shift left inside the tap window, feedback into bit0
    always_comb begin
        nxt_bwd = '0;
        nxt_bwd[TAP_HI:1] = state[TAP_HI-1:0];
        nxt_bwd[0] = state[0] ^ state[TAP_HI];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= '0;
        else if (load)
            state <= load_val;
        else if (fwd)
            state <= nxt_fwd;
        else if (bwd)
            state <= nxt_bwd;
    end
endmodule

// File: rtl/pll_mcode_div.sv
module pll_mcode_div #(
    parameter int DVD_W = 11,
    parameter int DVS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic             exact,
    output logic             done
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVS_W:0]   rem;
    logic [DVD_W-1:0] shq;
    logic [CNT_W-1:0] left;
    logic [DVS_W:0]   trial;
    logic             fits;

    assign trial = {rem[DVS_W-1:0], shq[DVD_W-1]};
    assign fits  = trial >= {1'b0, divisor};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            shq  <= '0;
            left <= '0;
        end else if (go) begin
            rem  <= '0;
            shq  <= dividend;
            left <= CNT_W'(DVD_W);
        end else if (left != '0) begin
            rem  <= fits ? (trial - {1'b0, divisor}) : trial;
            shq  <= {shq[DVD_W-2:0], fits};
            left <= left - 1'b1;
        end
    end

    assign quotient = shq;
    assign exact    = (rem == '0);
    assign done     = (left == '0);
endmodule

// File: rtl/pll_mcode_bw.sv
module pll_mcode_bw
    import pll_mcode_pkg::*;
(
    input  logic [MUL_W-1:0]  msel,
    input  logic [QUO_W-1:0]  quot,
    input  logic              exact,
    output logic [SELP_W-1:0] selp,
    output logic [SELI_W-1:0] seli
);
    logic [QUO_W-1:0] q_up;

    assign q_up = quot + QUO_W'(!exact);

    always_comb begin
        if (msel < MID_LO)
            selp = SELP_W'((msel >> 1) + 16'd1);
        else
            selp = SELP_W'(31);
    end

    always_comb begin
        if (msel > TH_SELI1)
            seli = SELI_W'(1);
        else if (msel > TH_SELI2)
            seli = SELI_W'(2);
        else if (msel > TH_SELI4)
            seli = SELI_W'(4);
        else if (msel > MID_HI)
            seli = SELI_W'(8);
        else if (msel >= MID_LO)
            seli = SELI_W'({q_up, 2'b00});
        else
            seli = SELI_W'((msel & 16'h003C) + 16'd4);
    end
endmodule

// File: rtl/pll_mcode_conv.sv
module pll_mcode_conv
    import pll_mcode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_dec,
    input  logic [MUL_W-1:0]  msel_in,
    input  logic [CODE_W-1:0] mdec_in,
    output logic              busy,
    output logic              valid,
    output logic [MUL_W-1:0]  msel_out,
    output logic [CODE_W-1:0] mdec_out,
    output logic [SELP_W-1:0] selp_out,
    output logic [SELI_W-1:0] seli_out,
    output logic              bad_code
);
    cvt_state_t        st, st_n;
    logic [MUL_W-1:0]  cnt, msel_r, bw_msel;
    logic [CODE_W-1:0] code, ld_val;
    logic              ld, fwd, bwd, div_go, div_done, div_exact;
    logic [QUO_W-1:0]  quo;
    logic [SELP_W-1:0] selp_c;
    logic [SELI_W-1:0] seli_c;
    logic              dec_special, enc_special, enc_end, dec_end, need_div;
    logic              enter_done;
    logic [MUL_W-1:0]  cap_msel;
    logic [CODE_W-1:0] cap_mdec;
    logic [SELP_W-1:0] cap_selp;
    logic [SELI_W-1:0] cap_seli;
    logic              cap_bad;

    assign dec_special = (mdec_in == CODE_M1) || (mdec_in == CODE_M2);
    assign enc_special = (msel_in <= 16'd2);
    assign enc_end     = (cnt > MSEL_TOP);
    assign dec_end     = (code == SEED) || (cnt == '0);
    assign need_div    = (msel_r >= MID_LO) && (msel_r <= MID_HI);

    pll_mcode_lfsr #(.CODE_W(CODE_W), .TAP_HI(TAP_HI)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .fwd(fwd), .bwd(bwd), .state(code)
    );

    pll_mcode_div #(.DVD_W(QUO_W), .DVS_W(DVS_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(BW_NUM),
        .divisor(DVS_W'(msel_r) + BW_OFS), .quotient(quo),
        .exact(div_exact), .done(div_done)
    );

    pll_mcode_bw u_bw (
        .msel(bw_msel), .quot(quo), .exact(div_exact),
        .selp(selp_c), .seli(seli_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    if (dir_dec)
                        st_n = dec_special ? S_DONE : S_DECODE;
                    else
                        st_n = enc_special ? S_DONE : S_ENCODE;
                end
            end
            S_ENCODE: if (enc_end) st_n = need_div ? S_DIVIDE : S_DONE;
            S_DIVIDE: if (div_done) st_n = S_DONE;
            S_DECODE: if (dec_end) st_n = S_DONE;
            S_DONE:   st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    // control outputs
    always_comb begin
        busy   = (st != S_IDLE);
        valid  = (st == S_DONE);
        ld     = (st == S_IDLE) && start;
        ld_val = dir_dec ? mdec_in : SEED;
        fwd    = (st == S_ENCODE) && !enc_end;
        bwd    = (st == S_DECODE) && !dec_end;
        div_go = (st == S_ENCODE) && enc_end && need_div;
    end

    // step counter and latched operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            msel_r <= '0;
        end else if (ld) begin
            msel_r <= msel_in;
            cnt    <= dir_dec ? DEC_START : msel_in;
        end else if (fwd) begin
            cnt <= cnt + 1'b1;
        end else if (bwd) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign bw_msel    = (st == S_IDLE) ? msel_in : msel_r;
    assign enter_done = (st_n == S_DONE) && (st != S_DONE);

    // values presented on entry to DONE
    always_comb begin
        cap_msel = '0;
        cap_mdec = '0;
        cap_selp = '0;
        cap_seli = '0;
        cap_bad  = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (dir_dec) begin
                    cap_msel = (mdec_in == CODE_M1) ? 16'd1 : 16'd2;
                end else begin
                    cap_msel = msel_in;
                    cap_mdec = (msel_in == 16'd1) ? CODE_M1 :
                               (msel_in == 16'd2) ? CODE_M2 : '0;
                    cap_selp = selp_c;
                    cap_seli = seli_c;
                end
            end
            S_ENCODE, S_DIVIDE: begin
                cap_msel = msel_r;
                cap_mdec = code;
                cap_selp = selp_c;
                cap_seli = seli_c;
            end
            S_DECODE: begin
                cap_bad  = (cnt == '0);
                cap_msel = cnt;
            end
            S_DONE: ;
            default: ;
        endcase
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msel_out <= '0;
            mdec_out <= '0;
            selp_out <= '0;
            seli_out <= '0;
            bad_code <= 1'b0;
        end else if (enter_done) begin
            msel_out <= cap_msel;
            mdec_out <= cap_mdec;
            selp_out <= cap_selp;
            seli_out <= cap_seli;
            bad_code <= cap_bad;
        end
    end
endmodule

// File: rtl/pll_mcode_chk.sv
module pll_mcode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        valid,
    input logic [15:0] msel_out,
    input logic [16:0] mdec_out,
    input logic [5:0]  seli_out,
    input logic        bad_code
);
    // R10
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    // R10
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !valid |=> busy);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R10
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);

    // R6
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && bad_code |-> msel_out == 16'd0 && seli_out == 6'd0);

    // R12
    msel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(msel_out) |-> valid);

    // R12
    mdec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdec_out) |-> valid);

    // R8
    seli_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && seli_out > 6'd2 |-> seli_out[1:0] == 2'b00);
endmodule

bind pll_mcode_conv pll_mcode_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .valid(valid),
    .msel_out(msel_out), .mdec_out(mdec_out), .seli_out(seli_out),
    .bad_code(bad_code)
);

// File: tb/tb_pll_mcode_conv.sv
module tb_pll_mcode_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_dec = 1'b0;
    logic [15:0] msel_in = '0;
    logic [16:0] mdec_in = '0;
    logic        busy, valid, bad_code;
    logic [15:0] msel_out;
    logic [16:0] mdec_out;
    logic [4:0]  selp_out;
    logic [5:0]  seli_out;

    always #10 clk = ~clk;

    pll_mcode_conv dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_dec(dir_dec),
        .msel_in(msel_in), .mdec_in(mdec_in), .busy(busy), .valid(valid),
        .msel_out(msel_out), .mdec_out(mdec_out), .selp_out(selp_out),
        .seli_out(seli_out), .bad_code(bad_code)
    );

    typedef struct {
        logic [16:0] mdec;
        logic [15:0] msel;
        logic [4:0]  selp;
        logic [5:0]  seli;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t got, last;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   done_flag = 0;

    function automatic logic [16:0] m_fwd(logic [16:0] x);
        logic [16:0] r;
        r = {1'b0, x[16:1]};
        r[14] = r[14] | (x[0] ^ x[1]);
        return r;
    endfunction

    function automatic logic [16:0] m_bwd(logic [16:0] x);
        return {2'b00, x[13:0], x[0] ^ x[14]};
    endfunction

    function automatic logic [16:0] m_enc(int m);
        logic [16:0] x;
        if (m == 0) return 17'h0;
        if (m == 1) return 17'h18003;
        if (m == 2) return 17'h10003;
        x = 17'h04000;
        for (int i = m; i <= 32768; i++) x = m_fwd(x);
        return x;
    endfunction

    function automatic int m_dec(logic [16:0] c);
        logic [16:0] x;
        int i;
        if (c == 17'h18003) return 1;
        if (c == 17'h10003) return 2;
        x = c;
        i = 32769;
        while (x != 17'h04000 && i > 0) begin
            x = m_bwd(x);
            i--;
        end
        return i;
    endfunction

    function automatic int m_selp(int m);
        return (m < 60) ? (m / 2) + 1 : 31;
    endfunction

    function automatic int m_seli(int m);
        int q, r;
        if (m > 16384) return 1;
        if (m > 8192) return 2;
        if (m > 2048) return 4;
        if (m >= 501) return 8;
        if (m >= 60) begin
            q = 1024 / (m + 9);
            r = 1024 % (m + 9);
            return (r == 0) ? 4 * q : 4 * (q + 1);
        end
        return (m & 60) + 4;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (sb.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R11 unexpected result actual msel=%0h expected none=0", msel_out);
            end else begin
                got = sb.pop_front();
                n_cmp++;
                if (mdec_out !== got.mdec || msel_out !== got.msel ||
                    selp_out !== got.selp || seli_out !== got.seli ||
                    bad_code !== got.bad) begin
                    n_bad++;
                    $display("FAIL %s actual mdec=%h msel=%0d selp=%0d seli=%0d bad=%b expected mdec=%h msel=%0d selp=%0d seli=%0d bad=%b",
                             got.tag, mdec_out, msel_out, selp_out, seli_out, bad_code,
                             got.mdec, got.msel, got.selp, got.seli, got.bad);
                end
                last = got;
            end
        end
    end

    task automatic issue(input bit d, input logic [15:0] m, input logic [16:0] c, input string tag);
        exp_t e;
        int r;
        if (!d) begin
            e.mdec = m_enc(int'(m));
            e.msel = m;
            e.selp = 5'(m_selp(int'(m)));
            e.seli = 6'(m_seli(int'(m)));
            e.bad  = 1'b0;
        end else begin
            r = m_dec(c);
            e.mdec = '0;
            e.msel = 16'(r);
            e.selp = '0;
            e.seli = '0;
            e.bad  = (r == 0);
        end
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b1;
        dir_dec = d;
        msel_in = m;
        mdec_in = c;
        @(negedge clk);
        start = 1'b0;
        // R10: busy rises on the clock that accepts start
        check(busy === 1'b1, "R10 busy after start", int'(busy), 1);
    endtask

    task automatic wait_result();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        // R10: busy drops after the valid cycle
        check(busy === 1'b0 && valid === 1'b0, "R10 idle after valid", int'({busy, valid}), 0);
    endtask

    task automatic run(input bit d, input logic [15:0] m, input logic [16:0] c, input string tag);
        issue(d, m, c, tag);
        wait_result();
    endtask

    task automatic hold_check(input string req);
        repeat (5) @(negedge clk);
        check(msel_out === last.msel && mdec_out === last.mdec &&
              selp_out === last.selp && seli_out === last.seli,
              req, int'(msel_out), int'(last.msel));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && valid === 1'b0 && bad_code === 1'b0, "R1 flags in reset",
              int'({busy, valid, bad_code}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(msel_out === '0 && mdec_out === '0 && selp_out === '0 && seli_out === '0,
              "R1 results after reset", int'(mdec_out), 0);

        run(0, 16'd0, '0, "R2 encode 0");
        run(0, 16'd1, '0, "R2 encode 1 R7 R8");
        run(0, 16'd2, '0, "R2 encode 2 R7 R8");
        hold_check("R12 hold after encode");
        run(0, 16'd32768, '0, "R3 encode top R7 R8");
        run(0, 16'd40000, '0, "R3 encode above range");
        run(0, 16'd65535, '0, "R3 encode max input");
        run(0, 16'd32000, '0, "R3 encode 32000");
        run(1, '0, 17'h18003, "R4 decode 0x18003");
        run(1, '0, 17'h10003, "R4 decode 0x10003");
        run(1, '0, m_enc(32000), "R5 decode code of 32000");
        run(1, '0, 17'h04000, "R5 decode seed");
        run(1, '0, 17'h12000, "R5 decode upper bits");
        hold_check("R12 hold after decode");

        // R11: a start during a long walk is ignored
        issue(0, 16'd32100, '0, "R11 encode with restart attempt");
        repeat (100) @(negedge clk);
        start = 1'b1;
        dir_dec = 1'b1;
        mdec_in = 17'h18003;
        msel_in = 16'd7;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R11 still busy", int'(busy), 1);
        wait_result();

        run(0, 16'd16384, '0, "R8 encode 16384");
        run(0, 16'd60, '0, "R9 encode 60 inexact R7");
        run(0, 16'd119, '0, "R9 encode 119 exact");
        run(1, '0, 17'h00000, "R6 decode unmatched");

        done_flag = 1;
        finish_run();
    end
endmodule